// File: doc/BRIEF.md
# Captured Patch Readout Sequencer

This block holds one captured data word per detector patch and hands the words out one at a time, one per read strobe. A capture pulse on a patch whose flag is clear stores that patch's word and raises its flag. Each read returns the word together with a one-hot tag that names the patch. The read also lowers that patch's flag, so no word is ever returned twice.

The order of readout is a hybrid. The patch that captured first after arming is always returned first. After that, the remaining flagged patches come out highest index first. A read that finds no flag set returns an all-zero word with the valid response low, and the reading side takes that as the end of the readout. A re-arm pulse clears every flag and the arrival record so that capture can start again.

Top module: `prs_readout_seq`

## Requirements
- R1: After reset every flag is clear, `rd_word` is all zeros and `rd_valid` is low.
- R2: A capture pulse on patch i with its flag clear stores bits [i*DATA_W +: DATA_W] of `cap_data` and sets the flag. A capture pulse on a patch whose flag is already set has no effect, and the first stored word is kept.
- R3: A valid read word carries the patch data in bits [DATA_W-1:0] and a one-hot patch tag in bits [DATA_W+NUM_PATCH-1:DATA_W]. Bit DATA_W+i marks patch i (0-based), so with the defaults bit 19 is patch 0 and bit 23 is patch 4.
- R4: The first read after arming that finds the first-arriving patch still flagged returns that patch, whatever its index.
- R5: When several flags rise in the same cycle and none has been recorded since arming, the highest-index patch among them counts as the first arrival.
- R6: Except for the pending first arrival, flagged patches are returned in descending index order.
- R7: A read clears the flag of the patch it returns, so a following read does not return that patch again unless it is captured again.
- R8: A read with no flag set drives `rd_word` to all zeros and `rd_valid` low.
- R9: `rd_word` and `rd_valid` change on the clock edge that samples `rd_strobe` high and hold their values while `rd_strobe` is low.
- R10: `rearm` clears all flags, the arrival record and both outputs, and enables the recording of a new first arrival. It overrides a capture or a read in the same cycle.
- R11: Only one first arrival is recorded per arming. After it has been read, a later capture of that patch, or of any other patch, is ordered by index alone.
- R12: A read in the same cycle as a capture does not see that capture. The captured patch becomes readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rearm | input | 1 | Clears flags, arrival record and outputs |
| cap_pulse | input | NUM_PATCH | One capture request per patch |
| cap_data | input | NUM_PATCH*DATA_W | Captured words, patch i in slice i |
| rd_strobe | input | 1 | Read command, one word per high cycle |
| rd_word | output | DATA_W+NUM_PATCH | Returned word: one-hot tag above data |
| rd_valid | output | 1 | High when rd_word holds captured data |

## Verification
Each read result is registered once. It appears on the edge that samples the strobe, so the bench drives inputs on the falling edge and compares the outputs on the next falling edge. A capture changes only internal state on its edge, so its effect is due in the result of a read one cycle later, and R12 checks exactly that one-cycle gap. Re-arm effects are due on the edge that samples `rearm`. The bench model updates its expected flags, arrival record and outputs for every edge in the same step order, so each comparison lands in the cycle its result is due.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int PRS_NUM_PATCH = 5;
    localparam int PRS_DATA_W    = 19;

    // Index of the highest set bit of v, zero when v is empty.
    function automatic int prs_highest(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/prs_flag_store.sv
module prs_flag_store
    import prs_pkg::*;
#(
    parameter int NUM_PATCH = PRS_NUM_PATCH,
    parameter int DATA_W    = PRS_DATA_W,
    localparam int IDX_W    = (NUM_PATCH > 1) ? $clog2(NUM_PATCH) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rearm,
    input  logic [NUM_PATCH-1:0]               cap_pulse,
    input  logic [NUM_PATCH*DATA_W-1:0]        cap_data,
    input  logic                               clr_valid,
    input  logic [IDX_W-1:0]                   clr_idx,
    output logic [NUM_PATCH-1:0]               flags_o,
    output logic [NUM_PATCH-1:0][DATA_W-1:0]   words_o,
    output logic [NUM_PATCH-1:0]               rise_o
);

    typedef struct packed {
        logic [NUM_PATCH-1:0]             flags;
        logic [NUM_PATCH-1:0][DATA_W-1:0] words;
    } store_t;

    store_t st_d, st_q;
    logic [NUM_PATCH-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        rise_o   = cap_pulse & ~st_q.flags & {NUM_PATCH{~rearm}};
        clr_mask = clr_valid ? (NUM_PATCH'(1) << clr_idx) : '0;
        if (rearm) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = (st_q.flags | rise_o) & ~clr_mask;
        end
        for (int i = 0; i < NUM_PATCH; i++) begin
            if (rise_o[i]) begin
                st_d.words[i] = cap_data[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign words_o = st_q.words;

endmodule

// File: rtl/prs_arrival_tracker.sv
module prs_arrival_tracker
    import prs_pkg::*;
#(
    parameter int NUM_PATCH = PRS_NUM_PATCH,
    localparam int IDX_W    = (NUM_PATCH > 1) ? $clog2(NUM_PATCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rearm,
    input  logic [NUM_PATCH-1:0] rise,
    input  logic                 clr_valid,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic                 first_pend_o,
    output logic [IDX_W-1:0]     first_idx_o
);

    typedef struct packed {
        logic             armed;
        logic             pend;
        logic [IDX_W-1:0] idx;
    } arr_t;

    arr_t ar_d, ar_q;

    always_comb begin
        ar_d = ar_q;
        if (rearm) begin
            ar_d.armed = 1'b1;
            ar_d.pend  = 1'b0;
        end else if (ar_q.armed && (|rise)) begin
            ar_d.armed = 1'b0;
            ar_d.pend  = 1'b1;
            ar_d.idx   = IDX_W'(prs_highest(32'(rise)));
        end else if (clr_valid && ar_q.pend && (clr_idx == ar_q.idx)) begin
            ar_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '{armed: 1'b1, pend: 1'b0, idx: '0};
        end else begin
            ar_q <= ar_d;
        end
    end

    assign first_pend_o = ar_q.pend;
    assign first_idx_o  = ar_q.idx;

endmodule

// File: rtl/prs_pick.sv
module prs_pick
    import prs_pkg::*;
#(
    parameter int NUM_PATCH = PRS_NUM_PATCH,
    localparam int IDX_W    = (NUM_PATCH > 1) ? $clog2(NUM_PATCH) : 1
) (
    input  logic [NUM_PATCH-1:0] flags,
    input  logic                 first_pend,
    input  logic [IDX_W-1:0]     first_idx,
    output logic                 pick_valid,
    output logic [IDX_W-1:0]     pick_idx
);

    always_comb begin
        pick_valid = |flags;
        if (first_pend && flags[first_idx]) begin
            pick_idx = first_idx;
        end else begin
            pick_idx = IDX_W'(prs_highest(32'(flags)));
        end
    end

endmodule

// File: rtl/prs_readout_seq.sv
module prs_readout_seq
    import prs_pkg::*;
#(
    parameter int NUM_PATCH = PRS_NUM_PATCH,
    parameter int DATA_W    = PRS_DATA_W,
    localparam int WORD_W   = DATA_W + NUM_PATCH,
    localparam int IDX_W    = (NUM_PATCH > 1) ? $clog2(NUM_PATCH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rearm,
    input  logic [NUM_PATCH-1:0]        cap_pulse,
    input  logic [NUM_PATCH*DATA_W-1:0] cap_data,
    input  logic                        rd_strobe,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        rd_valid
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_PATCH-1:0]             flags_w;
    logic [NUM_PATCH-1:0][DATA_W-1:0] words_w;
    logic [NUM_PATCH-1:0]             rise_w;
    logic                             first_pend_w;
    logic [IDX_W-1:0]                 first_idx_w;
    logic                             pick_valid_w;
    logic [IDX_W-1:0]                 pick_idx_w;
    logic                             clr_valid_w;

    assign clr_valid_w = rd_strobe & ~rearm & pick_valid_w;

    prs_flag_store #(
        .NUM_PATCH (NUM_PATCH),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rearm     (rearm),
        .cap_pulse (cap_pulse),
        .cap_data  (cap_data),
        .clr_valid (clr_valid_w),
        .clr_idx   (pick_idx_w),
        .flags_o   (flags_w),
        .words_o   (words_w),
        .rise_o    (rise_w)
    );

    prs_arrival_tracker #(
        .NUM_PATCH (NUM_PATCH)
    ) u_arrival (
        .clk          (clk),
        .rst_n        (rst_n),
        .rearm        (rearm),
        .rise         (rise_w),
        .clr_valid    (clr_valid_w),
        .clr_idx      (pick_idx_w),
        .first_pend_o (first_pend_w),
        .first_idx_o  (first_idx_w)
    );

    prs_pick #(
        .NUM_PATCH (NUM_PATCH)
    ) u_pick (
        .flags      (flags_w),
        .first_pend (first_pend_w),
        .first_idx  (first_idx_w),
        .pick_valid (pick_valid_w),
        .pick_idx   (pick_idx_w)
    );

    always_comb begin
        out_d = out_q;
        if (rearm) begin
            out_d = '0;
        end else if (rd_strobe) begin
            out_d.valid = pick_valid_w;
            if (pick_valid_w) begin
                out_d.word = {NUM_PATCH'(1) << pick_idx_w, words_w[pick_idx_w]};
            end else begin
                out_d.word = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_word  = out_q.word;
    assign rd_valid = out_q.valid;

endmodule

// File: rtl/prs_readout_checker.sv
module prs_readout_checker
    import prs_pkg::*;
#(
    parameter int NUM_PATCH = PRS_NUM_PATCH,
    parameter int DATA_W    = PRS_DATA_W,
    localparam int WORD_W   = DATA_W + NUM_PATCH,
    localparam int IDX_W    = (NUM_PATCH > 1) ? $clog2(NUM_PATCH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rearm,
    input logic                 rd_strobe,
    input logic [WORD_W-1:0]    rd_word,
    input logic                 rd_valid,
    input logic [NUM_PATCH-1:0] flags,
    input logic                 first_pend,
    input logic [IDX_W-1:0]     first_idx
);

    p_tag_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($countones(rd_word[WORD_W-1:DATA_W]) == 1));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_word == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !rearm) |=> ($stable(rd_word) && $stable(rd_valid)));

    p_rearm_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (!rd_valid && (flags == '0)));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rearm) |=> ((flags & rd_word[WORD_W-1:DATA_W]) == '0));

    p_first_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rearm && first_pend && flags[first_idx])
        |=> (rd_valid && rd_word[DATA_W + $past(first_idx)]));

endmodule

bind prs_readout_seq prs_readout_checker #(
    .NUM_PATCH (NUM_PATCH),
    .DATA_W    (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rearm      (rearm),
    .rd_strobe  (rd_strobe),
    .rd_word    (rd_word),
    .rd_valid   (rd_valid),
    .flags      (flags_w),
    .first_pend (first_pend_w),
    .first_idx  (first_idx_w)
);

// File: tb/tb_prs_readout_seq.sv
module tb_prs_readout_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int DW = 19;
    localparam int WW = DW + NP;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rearm;
    logic [NP-1:0]     cap_pulse;
    logic [NP*DW-1:0]  cap_data;
    logic              rd_strobe;
    logic [WW-1:0]     rd_word;
    logic              rd_valid;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model state
    logic [NP-1:0] m_flag;
    logic [DW-1:0] m_word [NP];
    bit            m_armed;
    bit            m_pend;
    int            m_first;
    logic [WW-1:0] exp_word;
    logic          exp_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    prs_readout_seq #(.NUM_PATCH(NP), .DATA_W(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rearm     (rearm),
        .cap_pulse (cap_pulse),
        .cap_data  (cap_data),
        .rd_strobe (rd_strobe),
        .rd_word   (rd_word),
        .rd_valid  (rd_valid)
    );

    function automatic int top_set(input logic [NP-1:0] v);
        int r;
        r = -1;
        for (int i = 0; i < NP; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic int next_pick();
        if (m_pend && m_flag[m_first]) return m_first;
        return top_set(m_flag);
    endfunction

    function automatic logic [NP*DW-1:0] rand_data();
        logic [NP*DW-1:0] d;
        for (int i = 0; i < NP; i++) d[i*DW +: DW] = DW'($urandom);
        return d;
    endfunction

    function automatic logic [NP*DW-1:0] one_data(input int p, input logic [DW-1:0] v);
        logic [NP*DW-1:0] d;
        d = '0;
        d[p*DW +: DW] = v;
        return d;
    endfunction

    task automatic model_reset();
        m_flag = '0; m_armed = 1'b1; m_pend = 1'b0; m_first = 0;
        exp_word = '0; exp_valid = 1'b0;
        for (int i = 0; i < NP; i++) m_word[i] = '0;
    endtask

    task automatic model_edge(input logic [NP-1:0] cap, input logic [NP*DW-1:0] data,
                              input logic rd, input logic ra);
        logic [NP-1:0] rise;
        int pk;
        rise = ra ? '0 : (cap & ~m_flag);
        pk = next_pick();
        if (ra) begin
            exp_word = '0; exp_valid = 1'b0;
            m_flag = '0; m_armed = 1'b1; m_pend = 1'b0;
        end else begin
            if (rd) begin
                if (pk >= 0) begin
                    exp_word = {NP'(1) << pk, m_word[pk]};
                    exp_valid = 1'b1;
                    m_flag[pk] = 1'b0;
                    if (m_pend && pk == m_first) m_pend = 1'b0;
                end else begin
                    exp_word = '0; exp_valid = 1'b0;
                end
            end
            for (int i = 0; i < NP; i++) begin
                if (rise[i]) begin
                    m_flag[i] = 1'b1;
                    m_word[i] = data[i*DW +: DW];
                end
            end
            if (m_armed && (|rise)) begin
                m_armed = 1'b0; m_pend = 1'b1; m_first = top_set(rise);
            end
        end
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (rd_word !== exp_word || rd_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
                     tag, rd_word, rd_valid, exp_word, exp_valid);
        end
    endtask

    // called at a falling edge; result compared at the next falling edge
    task automatic step(input logic [NP-1:0] cap, input logic [NP*DW-1:0] data,
                        input logic rd, input logic ra, input string tag);
        cap_pulse = cap; cap_data = data; rd_strobe = rd; rearm = ra;
        model_edge(cap, data, rd, ra);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rd_only(input string tag);
        step('0, '0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1c3a_77e5);
        rst_n = 1'b0; rearm = 1'b0; cap_pulse = '0; cap_data = '0; rd_strobe = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        rd_only("R1");                                   // empty after reset

        // R2: capture, then a second capture on the same patch is ignored
        step(5'b00010, one_data(1, 19'h1_2345), 1'b0, 1'b0, "R2");
        step(5'b00010, one_data(1, 19'h7_0F0F), 1'b0, 1'b0, "R2");
        step(5'b10000, one_data(4, 19'h5_5555), 1'b0, 1'b0, "R2");
        step(5'b00101, one_data(0, 19'h0_00A1) | one_data(2, 19'h2_00C3), 1'b0, 1'b0, "R2");
        rd_only("R4");                                   // patch 1 first, holds first word
        rd_only("R3");                                   // patch 4, tag bit 23
        rd_only("R6");                                   // patch 2
        rd_only("R6");                                   // patch 0
        rd_only("R7");                                   // nothing repeated
        // R5 and R11 after a rearm
        step('0, '0, 1'b0, 1'b1, "R10");
        step(5'b00101, one_data(0, 19'h0_1111) | one_data(2, 19'h0_2222), 1'b0, 1'b0, "R5");
        step(5'b10000, one_data(4, 19'h0_4444), 1'b0, 1'b0, "R11");
        rd_only("R5");                                   // patch 2 counts as first
        rd_only("R6");                                   // patch 4
        step(5'b01100, one_data(2, 19'h3_3333) | one_data(3, 19'h3_0003), 1'b0, 1'b0, "R11");
        rd_only("R11");                                  // patch 3 ahead of recaptured 2
        rd_only("R11");                                  // patch 2
        rd_only("R6");                                   // patch 0
        rd_only("R8");                                   // empty
        // R12: a capture in the read cycle is not seen by that read
        step('0, '0, 1'b0, 1'b1, "R10");
        step(5'b00010, one_data(1, 19'h6_1234), 1'b1, 1'b0, "R12");
        rd_only("R12");
        // R10: rearm overrides a capture and a read in the same cycle
        step(5'b01000, one_data(3, 19'h1_ABCD), 1'b0, 1'b0, "R2");
        step(5'b01000, one_data(3, 19'h2_BCDE), 1'b1, 1'b1, "R10");
        rd_only("R10");
        // R9: outputs hold while no read
        step(5'b00001, one_data(0, 19'h4_0C0C), 1'b0, 1'b0, "R2");
        rd_only("R9");
        step('0, '0, 1'b0, 1'b0, "R9");
        step(5'b00100, one_data(2, 19'h0_7777), 1'b0, 1'b0, "R9");

        for (int n = 0; n < 3000; n++) begin
            logic [NP-1:0] cap;
            logic rd, ra;
            int pk;
            string tag;
            for (int i = 0; i < NP; i++) cap[i] = ($urandom % 6) == 0;
            rd = ($urandom % 3) == 0;
            ra = ($urandom % 50) == 0;
            pk = next_pick();
            if (ra)                               tag = "R10";
            else if (!rd)                         tag = "R9";
            else if (pk < 0)                      tag = "R8";
            else if (m_pend && pk == m_first)     tag = "R4";
            else                                  tag = "R6";
            step(cap, rand_data(), rd, ra, tag);
        end
        // drain what is left
        for (int n = 0; n < NP + 1; n++) rd_only("R7");

        cap_pulse = '0; rd_strobe = 1'b0; rearm = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule